// File: doc/BRIEF.md
# Crosspoint Routing Configuration Port

This block is the serial programming port of a routing matrix controller that connects up to 32 sources to 16 destinations. A host streams configuration bits one per rising clock edge while the active-low select is held low. The bits collect in a shift register as long as one whole frame. A second register stage, the update stage, copies the shift register whenever the active-low update strobe is low. That stage drives the routing outputs: a source select and an enable for each destination, a global clamp-enable flag, and a test-mode flag.

A frame starts with the clamp bit. The fields for destination 15 down to destination 0 follow it. Each field is an enable bit and then a select value sent most significant bit first. The frame ends with padding bits that must all be zero. The bit that leaves the far end of the shift register appears on a serial output, so several ports can share one stream through a daisy chain. The host sends the data for the last port in the chain first.

While the update strobe stays low, the update stage reloads on every clock, so a frame shifted in during that time passes through every partial state on its way in. An asynchronous active-low reset clears every output enable and the flags at once. Its release is synchronised to the clock.

Top module: `xbar_cfg_port`

## Requirements
- R1: A frame is 1 + 16×6 + 96 = 193 bits long. The first bit shifted in leaves on `sdo` exactly 193 shifts after it entered, and not before.
- R2: A rising clock edge shifts `sdi` into the register only while `cs_n` is 0. While `cs_n` is 1, both the register contents and `sdo` stay unchanged.
- R3: Field order, oldest bit first: the clamp bit, then destination 15 through destination 0, each sent as the enable bit followed by select bits 4 down to 0. After an update, `clamp_en`, `route_en[k]` and `route_sel[k*5 +: 5]` show the fields of the last 193 bits shifted in.
- R4: A destination whose latched enable is 0 presents a select of 0, whatever select bits were shifted in for it.
- R5: On each update, `test_mode` becomes 1 if any of the 96 padding bits (the last 96 bits shifted) is 1, and 0 otherwise.
- R6: On every rising edge with `upd_n` = 0, the update stage loads the shift register contents as they stand after that edge's shift. While `upd_n` = 1, the outputs hold.
- R7: While `rst_n` is 0, `route_en`, `route_sel`, `clamp_en`, `test_mode` and `sdo` are 0, starting immediately and without waiting for a clock edge.
- R8: `sdo` is the oldest bit held in the shift register and changes only on a rising edge with `cs_n` = 0. A second frame shifted in behind a first one brings the first frame out on `sdo` in its original order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial and update clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cs_n | input | 1 | Active-low select; shifting happens only while low |
| sdi | input | 1 | Serial configuration data in |
| upd_n | input | 1 | Active-low update strobe; the outputs reload every cycle it is low |
| sdo | output | 1 | Oldest bit in the shift register, for daisy chaining |
| route_en | output | 16 | Per-destination enable, bit k for destination k |
| route_sel | output | 80 | Per-destination source select, destination k at bits [k*5 +: 5] |
| clamp_en | output | 1 | Global clamp enable |
| test_mode | output | 1 | Set when the latched padding bits were nonzero |

## Verification
The bench builds the port with its default parameters: 16 destinations, 5-bit selects and 96 padding bits, which gives the full 193-bit frame. At this size a complete chaining pass fits in a short run, and the bench can line up every bit of one frame as it comes out on `sdo` behind the next. The 96-bit padding is split into several reduction chunks at these values, so a single set bit near either end of the padding reaches the test flag through a different chunk.

// File: rtl/xbar_cfg_pkg.sv
package xbar_cfg_pkg;

  // Bit index of the enable for destination idx within the shift register.
  // The oldest bit sits at index frame_w-1 and holds the clamp flag.
  function automatic int unsigned en_index(input int unsigned idx,
                                           input int unsigned n_dest,
                                           input int unsigned field_w,
                                           input int unsigned frame_w);
    return frame_w - 2 - (n_dest - 1 - idx) * field_w;
  endfunction

  function automatic int unsigned ceil_div(input int unsigned a,
                                           input int unsigned b);
    return (a + b - 1) / b;
  endfunction

endpackage

// File: rtl/xbar_rst_sync.sv
module xbar_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/xbar_shift_reg.sv
module xbar_shift_reg #(
  parameter int unsigned WIDTH = 193
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             sin,
  output logic [WIDTH-1:0] sr_next,
  output logic [WIDTH-1:0] sr_q,
  output logic             sout
);

  always_comb begin
    if (shift_en) sr_next = {sr_q[WIDTH-2:0], sin};
    else          sr_next = sr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sr_q <= '0;
    else if (shift_en) sr_q <= sr_next;
  end

  assign sout = sr_q[WIDTH-1];

endmodule

// File: rtl/xbar_field_latch.sv
module xbar_field_latch #(
  parameter int unsigned SEL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             en_o,
  output logic [SEL_W-1:0] sel_o
);

  logic             en_q, en_d;
  logic [SEL_W-1:0] sel_q, sel_d;

  always_comb begin
    en_d  = en_q;
    sel_d = sel_q;
    if (load) begin
      en_d  = en_i;
      sel_d = sel_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      sel_q <= '0;
    end else begin
      en_q  <= en_d;
      sel_q <= sel_d;
    end
  end

  assign en_o  = en_q;
  assign sel_o = en_q ? sel_q : '0;

endmodule

// File: rtl/xbar_pad_detect.sv
module xbar_pad_detect #(
  parameter int unsigned PAD_W   = 96,
  parameter int unsigned CHUNK_W = 16
) (
  input  logic [PAD_W-1:0] pad_i,
  output logic             hit_o
);

  localparam int unsigned NCHUNK = xbar_cfg_pkg::ceil_div(PAD_W, CHUNK_W);
  localparam int unsigned EXT_W  = NCHUNK * CHUNK_W;

  logic [EXT_W-1:0]  pad_ext;
  logic [NCHUNK-1:0] chunk_hit;

  assign pad_ext = EXT_W'(pad_i);

  for (genvar c = 0; c < NCHUNK; c++) begin : g_chunk
    assign chunk_hit[c] = |pad_ext[c*CHUNK_W +: CHUNK_W];
  end

  assign hit_o = |chunk_hit;

endmodule

// File: rtl/xbar_cfg_port.sv
module xbar_cfg_port #(
  parameter int unsigned N_DEST  = 16,
  parameter int unsigned SEL_W   = 5,
  parameter int unsigned PAD_W   = 96,
  parameter int unsigned CHUNK_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cs_n,
  input  logic                    sdi,
  input  logic                    upd_n,
  output logic                    sdo,
  output logic [N_DEST-1:0]       route_en,
  output logic [N_DEST*SEL_W-1:0] route_sel,
  output logic                    clamp_en,
  output logic                    test_mode
);

  localparam int unsigned FIELD_W = SEL_W + 1;
  localparam int unsigned FRAME_W = 1 + N_DEST * FIELD_W + PAD_W;

  logic               rst_n_s;
  logic               shift_en;
  logic               load;
  logic [FRAME_W-1:0] sr_next;
  logic [FRAME_W-1:0] sreg_bits;
  logic               pad_hit;
  logic               clamp_q, clamp_d;
  logic               test_q, test_d;

  xbar_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_n_s)
  );

  assign shift_en = ~cs_n;
  assign load     = ~upd_n;

  xbar_shift_reg #(.WIDTH(FRAME_W)) u_sreg (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .shift_en (shift_en),
    .sin      (sdi),
    .sr_next  (sr_next),
    .sr_q     (sreg_bits),
    .sout     (sdo)
  );

  for (genvar k = 0; k < N_DEST; k++) begin : g_dest
    localparam int unsigned EN_IDX =
      xbar_cfg_pkg::en_index(k, N_DEST, FIELD_W, FRAME_W);
    xbar_field_latch #(.SEL_W(SEL_W)) u_field (
      .clk   (clk),
      .rst_n (rst_n_s),
      .load  (load),
      .en_i  (sr_next[EN_IDX]),
      .sel_i (sr_next[EN_IDX-1 -: SEL_W]),
      .en_o  (route_en[k]),
      .sel_o (route_sel[k*SEL_W +: SEL_W])
    );
  end

  xbar_pad_detect #(.PAD_W(PAD_W), .CHUNK_W(CHUNK_W)) u_pad (
    .pad_i (sr_next[PAD_W-1:0]),
    .hit_o (pad_hit)
  );

  always_comb begin
    clamp_d = clamp_q;
    test_d  = test_q;
    if (load) begin
      clamp_d = sr_next[FRAME_W-1];
      test_d  = pad_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      clamp_q <= 1'b0;
      test_q  <= 1'b0;
    end else begin
      clamp_q <= clamp_d;
      test_q  <= test_d;
    end
  end

  assign clamp_en  = clamp_q;
  assign test_mode = test_q;

endmodule

// File: rtl/xbar_cfg_port_checker.sv
module xbar_cfg_port_checker #(
  parameter int unsigned N_DEST = 16,
  parameter int unsigned SEL_W  = 5,
  parameter int unsigned PAD_W  = 96
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cs_n,
  input logic                    upd_n,
  input logic                    sdo,
  input logic [N_DEST-1:0]       route_en,
  input logic [N_DEST*SEL_W-1:0] route_sel,
  input logic                    clamp_en,
  input logic                    test_mode,
  input logic [1:0]              sreg_hi,
  input logic [PAD_W-1:0]        pad_bits
);

  logic sel_quiet;

  always_comb begin
    sel_quiet = 1'b1;
    for (int k = 0; k < N_DEST; k++) begin
      if (!route_en[k] && (route_sel[k*SEL_W +: SEL_W] != '0)) sel_quiet = 1'b0;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_CLEARS: assert (route_en == '0 && !clamp_en && !test_mode && !sdo); // R7
    end
  end

  AST_IDLE_SDO_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> $stable(sdo)); // R2

  AST_SDO_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |=> sdo == $past(sreg_hi[0])); // R8

  AST_OUTPUTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    upd_n |=> ($stable(route_en) && $stable(route_sel) && $stable(clamp_en) && $stable(test_mode))); // R6

  AST_CLAMP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_n |=> clamp_en == sreg_hi[1]); // R6

  AST_TEST_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_n |=> test_mode == (|pad_bits)); // R5

  AST_DISABLED_SEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sel_quiet); // R4

endmodule

bind xbar_cfg_port xbar_cfg_port_checker #(
  .N_DEST (N_DEST),
  .SEL_W  (SEL_W),
  .PAD_W  (PAD_W)
) u_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .upd_n     (upd_n),
  .sdo       (sdo),
  .route_en  (route_en),
  .route_sel (route_sel),
  .clamp_en  (clamp_en),
  .test_mode (test_mode),
  .sreg_hi   (sreg_bits[FRAME_W-1 -: 2]),
  .pad_bits  (sreg_bits[PAD_W-1:0])
);

// File: tb/xbar_cfg_port_bench.sv
`timescale 1ns/1ps
module xbar_cfg_port_bench;

  localparam int ND = 16;
  localparam int SW = 5;
  localparam int PD = 96;
  localparam int FD = SW + 1;
  localparam int FW = 1 + ND * FD + PD;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sdi = 1'b0;
  logic upd_n = 1'b1;
  logic sdo;
  logic [ND-1:0]    route_en;
  logic [ND*SW-1:0] route_sel;
  logic clamp_en, test_mode;

  always #2.5 clk = ~clk;

  xbar_cfg_port u_xbar_cfg_port (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdi(sdi), .upd_n(upd_n),
    .sdo(sdo), .route_en(route_en), .route_sel(route_sel),
    .clamp_en(clamp_en), .test_mode(test_mode)
  );

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  task automatic chk(input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference: a queue of bits, oldest first.
  bit q[$];
  logic          m_clamp, m_test;
  logic [ND-1:0] m_en;
  logic [SW-1:0] m_sel [ND];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      for (int i = 0; i < FW; i++) q.push_back(1'b0);
      m_clamp = 0; m_test = 0; m_en = '0;
      for (int k = 0; k < ND; k++) m_sel[k] = '0;
    end else begin
      if (!cs_n) begin
        q.push_back(sdi);
        void'(q.pop_front());
      end
      if (!upd_n) begin
        m_clamp = q[0];
        for (int k = 0; k < ND; k++) begin
          m_en[k] = q[1 + (ND - 1 - k) * FD];
          for (int b = 0; b < SW; b++) m_sel[k][SW-1-b] = q[2 + (ND - 1 - k) * FD + b];
        end
        m_test = 0;
        for (int i = FW - PD; i < FW; i++) if (q[i]) m_test = 1;
      end
    end
  end

  function automatic logic [ND*SW-1:0] exp_sel();
    logic [ND*SW-1:0] r = '0;
    for (int k = 0; k < ND; k++) if (m_en[k]) r[k*SW +: SW] = m_sel[k];
    return r;
  endfunction

  bit cmp_on = 0;
  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R3 R6", "route_en", route_en, m_en);
      chk("R3 R4", "route_sel", route_sel, exp_sel());
      chk("R3", "clamp_en", clamp_en, m_clamp);
      chk("R5", "test_mode", test_mode, m_test);
      chk("R8", "sdo", sdo, q[0]);
    end
  end

  // Frame stimulus
  logic [ND-1:0] f_en;
  logic [SW-1:0] f_sel [ND];
  logic          f_clamp;
  int            f_pad_pos;   // -1: clean padding
  bit fb [FW];
  bit fb_prev [FW];
  bit seen [FW];

  task automatic build_frame();
    int p = 0;
    for (int i = 0; i < FW; i++) fb_prev[i] = fb[i];
    fb[p++] = f_clamp;
    for (int k = ND - 1; k >= 0; k--) begin
      fb[p++] = f_en[k];
      for (int b = SW - 1; b >= 0; b--) fb[p++] = f_sel[k][b];
    end
    for (int i = 0; i < PD; i++) fb[p++] = (i == f_pad_pos);
  endtask

  task automatic send_frame(input bit hold_upd_low);
    build_frame();
    for (int j = 0; j < FW; j++) begin
      @(negedge clk);
      seen[j] = sdo;
      cs_n = 0; sdi = fb[j]; upd_n = hold_upd_low ? 1'b0 : 1'b1;
    end
    @(negedge clk);
    cs_n = 1; upd_n = 1;
  endtask

  task automatic pulse_upd();
    @(negedge clk); cs_n = 1; upd_n = 0;
    @(negedge clk); upd_n = 1;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); cs_n = 1; upd_n = 1; end
  endtask

  task automatic check_frame_out(input string req);
    for (int k = 0; k < ND; k++) begin
      chk(req, $sformatf("en[%0d]", k), route_en[k], f_en[k]);
      chk(req, $sformatf("sel[%0d]", k), route_sel[k*SW +: SW], f_en[k] ? f_sel[k] : '0);
    end
    chk(req, "clamp_en", clamp_en, f_clamp);
    chk(req, "test_mode", test_mode, f_pad_pos >= 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [ND-1:0] snap_en;
    logic          snap_sdo;
    bit            chain_ok;
    for (int i = 0; i < FW; i++) fb[i] = 0;
    repeat (3) @(negedge clk);
    #1;
    // R7 reset state
    chk("R7", "reset route_en", route_en, '0);
    chk("R7", "reset route_sel", route_sel, '0);
    chk("R7", "reset flags", {clamp_en, test_mode, sdo}, 3'b000);
    @(negedge clk); rst_n = 1;
    idle(4);
    cmp_on = 1;

    // Frame A: upd_n high while shifting, outputs must hold (R6)
    f_clamp = 1; f_pad_pos = -1;
    for (int k = 0; k < ND; k++) begin f_en[k] = (k % 3 != 0); f_sel[k] = SW'(k * 7 + 3); end
    send_frame(0);
    chk("R1", "sdo one shift before frame end", seen[FW-1], 1'b0);
    chk("R1", "sdo at frame end", sdo, 1'b1);
    chk("R6", "hold while upd_n high", route_en, '0);
    pulse_upd();
    check_frame_out("R3");

    // R4: disabled outputs with all-ones selects
    f_clamp = 0; f_pad_pos = -1;
    for (int k = 0; k < ND; k++) begin f_en[k] = k[0]; f_sel[k] = '1; end
    send_frame(0);
    // R8: frame A leaves on sdo in original order
    chain_ok = 1;
    for (int j = 0; j < FW; j++) if (seen[j] != fb_prev[j]) chain_ok = 0;
    chk("R8", "chained frame order", chain_ok, 1'b1);
    pulse_upd();
    check_frame_out("R4");
    chk("R4", "disabled dest 0 select", route_sel[0 +: SW], '0);

    // R5: padding bit set at the far end, then near end
    f_clamp = 1; f_pad_pos = PD - 1;
    for (int k = 0; k < ND; k++) begin f_en[k] = 1; f_sel[k] = SW'(31 - k); end
    send_frame(0); pulse_upd();
    chk("R5", "test flag last pad bit", test_mode, 1'b1);
    f_pad_pos = 0;
    send_frame(0); pulse_upd();
    chk("R5", "test flag first pad bit", test_mode, 1'b1);
    f_pad_pos = -1;
    send_frame(0); pulse_upd();
    chk("R5", "test flag clean", test_mode, 1'b0);

    // R2: cs_n high, data toggles, then update: nothing changes
    snap_en = route_en; snap_sdo = sdo;
    for (int i = 0; i < 20; i++) begin @(negedge clk); cs_n = 1; sdi = i[0]; end
    chk("R2", "sdo while deselected", sdo, snap_sdo);
    pulse_upd();
    chk("R2", "outputs after idle update", route_en, snap_en);

    // R6: ripple with upd_n held low, no separate pulse
    f_clamp = 0; f_pad_pos = 40;
    for (int k = 0; k < ND; k++) begin f_en[k] = (k < 8); f_sel[k] = SW'(k + 16); end
    send_frame(1);
    check_frame_out("R6");

    // R7: asynchronous reset in mid cycle
    f_clamp = 1; f_pad_pos = -1;
    for (int k = 0; k < ND; k++) begin f_en[k] = 1; f_sel[k] = SW'(k); end
    send_frame(0); pulse_upd();
    @(negedge clk); #1; rst_n = 0; #0.5;
    chk("R7", "async reset route_en", route_en, '0);
    chk("R7", "async reset flags", {clamp_en, test_mode, sdo}, 3'b000);
    chk("R7", "async reset route_sel", route_sel, '0);
    @(negedge clk); @(negedge clk); rst_n = 1;
    idle(4);
    chk("R7", "after reset release", route_en, '0);

    idle(2);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule